// File: doc/BRIEF.md
# Decrementer Timer

A processor-side countdown timer with a small register file. A count register moves down by one on every cycle of a timebase strobe. When it steps from one to zero it raises a sticky expiry event flag. After expiry the counter either parks at zero or reloads from a reload register and keeps running, depending on a control bit. The event flag leaves the block as a level interrupt, gated by a local enable in the control register and by a global enable input.

Software reaches four 32-bit registers through a synchronous register bus: count, control, status and reload. Reads are combinational on the address. Writes take effect at the clock edge. The status register is a clear mask: software acknowledges the event by writing a 1 in the event bit's position. An event that the hardware raises in the same cycle as a clear is kept.

Top module: `dec_timer`

## Requirements
- R1: When the count is nonzero and the `tick` strobe is high, the count drops by one at the clock edge. With `tick` low and no count write, the count holds.
- R2: On a `tick` with count equal to 1, the event flag (status bit 27) becomes 1. The flag never becomes 1 without such an expiry.
- R3: When the auto-reload bit (control bit 22) is 0, expiry leaves the count at 0. Further ticks keep it at 0.
- R4: When the auto-reload bit is 1, expiry loads the count from the reload register and counting continues. The event flag is still set.
- R5: The local interrupt enable (control bit 26) gates only the output. With it at 0, expiry still sets the event flag and `irq_o` stays low.
- R6: `irq_o` is high exactly when the event flag, the local enable and `glob_ie` are all 1. Clearing any one of them drops it.
- R7: A status write clears the event flag when write-data bit 27 is 1 and leaves the flag unchanged when that bit is 0. The flag is otherwise sticky.
- R8: Writing the local enable to 1 while the event flag is already 1 raises `irq_o` in the cycle right after the write edge.
- R9: A count write loads the write data into the count. It takes priority over an expiry in the same cycle, and that expiry then sets no event.
- R10: If an expiry and a status clear of the event bit fall in the same cycle, the event flag ends up at 1.
- R11: After reset all four registers read 0 and `irq_o` is 0.
- R12: Register addresses are 0 count, 1 control, 2 status, 3 reload. Control bits other than 26 and 22 read 0, and status bits other than 27 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus access select |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick | input | 1 | Timebase strobe, one count step per high cycle |
| glob_ie | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bound checker watches every cycle. It checks the single-step decrement and the hold, the set of the event flag only on expiry, the park-at-zero and reload targets, the priority of count writes and of a hardware set over a clear, the stickiness of the flag, and that `irq_o` never rises without the flag, the local enable and the global enable. The bench scenarios show what depends on sequences and on the register view: the read-back encoding and the zero-reading unused bits, an enable written while an event is pending, mask writes carrying 0 against 1, and long random mixes of writes, strobes and enable changes checked against a reference model.

// File: rtl/dec_timer_pkg.sv
package dec_timer_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned IE_POS   = 26;
  localparam int unsigned AUTO_POS = 22;
  localparam int unsigned EV_POS   = 27;

  typedef enum logic [ADDR_W-1:0] {
    REG_COUNT  = 2'd0,
    REG_CTRL   = 2'd1,
    REG_STATUS = 2'd2,
    REG_RELOAD = 2'd3
  } dec_reg_e;

  typedef struct packed {
    logic wr_count;
    logic wr_ctrl;
    logic wr_status;
    logic wr_reload;
  } dec_wstb_t;
endpackage

// File: rtl/dec_regif.sv
module dec_regif
  import dec_timer_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     count_rd,
  input  logic [DW-1:0]     ctrl_rd,
  input  logic [DW-1:0]     status_rd,
  input  logic [DW-1:0]     reload_rd,
  output dec_wstb_t         wstb,
  output logic [DW-1:0]     bus_rdata
);
  logic     wr_any;
  dec_reg_e sel_reg;

  assign wr_any  = bus_sel & bus_wr;
  assign sel_reg = dec_reg_e'(bus_addr);

  always_comb begin
    wstb = '0;
    if (wr_any) begin
      unique case (sel_reg)
        REG_COUNT:  wstb.wr_count  = 1'b1;
        REG_CTRL:   wstb.wr_ctrl   = 1'b1;
        REG_STATUS: wstb.wr_status = 1'b1;
        REG_RELOAD: wstb.wr_reload = 1'b1;
        default:    wstb = '0;
      endcase
    end
  end

  always_comb begin
    unique case (sel_reg)
      REG_COUNT:  bus_rdata = count_rd;
      REG_CTRL:   bus_rdata = ctrl_rd;
      REG_STATUS: bus_rdata = status_rd;
      REG_RELOAD: bus_rdata = reload_rd;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dec_counter.sv
module dec_counter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          auto_rl,
  input  logic          wr_count,
  input  logic          wr_reload,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] count_q,
  output logic [DW-1:0] reload_q,
  output logic          expire
);
  localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] ZERO = '0;

  logic [DW-1:0] count_d;
  logic [DW-1:0] reload_d;
  logic          count_en;
  logic          running;

  assign running = (count_q != ZERO);

  // next state: software write beats the strobe
  always_comb begin
    count_d  = count_q;
    count_en = 1'b0;
    expire   = 1'b0;
    if (wr_count) begin
      count_d  = wdata;
      count_en = 1'b1;
    end else if (tick && running) begin
      count_en = 1'b1;
      if (count_q == ONE) begin
        expire  = 1'b1;
        count_d = auto_rl ? reload_q : ZERO;
      end else begin
        count_d = count_q - ONE;
      end
    end
  end

  assign reload_d = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (wr_reload) begin
      reload_q <= reload_d;
    end
  end
endmodule

// File: rtl/dec_ctlstat.sv
module dec_ctlstat #(
  parameter int unsigned DW       = 32,
  parameter int unsigned IE_BIT   = 26,
  parameter int unsigned AUTO_BIT = 22,
  parameter int unsigned EV_BIT   = 27
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_status,
  input  logic          ie_wd,
  input  logic          auto_wd,
  input  logic          clr_wd,
  input  logic          expire,
  input  logic          glob_ie,
  output logic          ie_q,
  output logic          auto_q,
  output logic          ev_q,
  output logic          clr_ev,
  output logic [DW-1:0] ctrl_rd,
  output logic [DW-1:0] status_rd,
  output logic          irq_o
);
  logic ie_d;
  logic auto_d;
  logic ev_d;
  logic ev_en;

  assign clr_ev = wr_status & clr_wd;

  always_comb begin
    ie_d   = ie_wd;
    auto_d = auto_wd;
  end

  // hardware set dominates the mask clear
  always_comb begin
    ev_en = expire | clr_ev;
    if (expire) begin
      ev_d = 1'b1;
    end else begin
      ev_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      auto_q <= 1'b0;
    end else if (wr_ctrl) begin
      ie_q   <= ie_d;
      auto_q <= auto_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q <= 1'b0;
    end else if (ev_en) begin
      ev_q <= ev_d;
    end
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[IE_BIT]   = ie_q;
    ctrl_rd[AUTO_BIT] = auto_q;
  end

  always_comb begin
    status_rd         = '0;
    status_rd[EV_BIT] = ev_q;
  end

  assign irq_o = ev_q & ie_q & glob_ie;
endmodule

// File: rtl/dec_timer.sv
module dec_timer
  import dec_timer_pkg::*;
#(
  parameter int unsigned DW       = DATA_W,
  parameter int unsigned IE_BIT   = IE_POS,
  parameter int unsigned AUTO_BIT = AUTO_POS,
  parameter int unsigned EV_BIT   = EV_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              tick,
  input  logic              glob_ie,
  output logic              irq_o
);
  dec_wstb_t     wstb;
  logic [DW-1:0] count_val;
  logic [DW-1:0] reload_val;
  logic [DW-1:0] ctrl_rd;
  logic [DW-1:0] status_rd;
  logic          expire;
  logic          ie_val;
  logic          auto_val;
  logic          ev_val;
  logic          clr_ev;

  dec_regif #(.DW(DW)) u_regif (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .count_rd  (count_val),
    .ctrl_rd   (ctrl_rd),
    .status_rd (status_rd),
    .reload_rd (reload_val),
    .wstb      (wstb),
    .bus_rdata (bus_rdata)
  );

  dec_counter #(.DW(DW)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .auto_rl   (auto_val),
    .wr_count  (wstb.wr_count),
    .wr_reload (wstb.wr_reload),
    .wdata     (bus_wdata),
    .count_q   (count_val),
    .reload_q  (reload_val),
    .expire    (expire)
  );

  dec_ctlstat #(
    .DW       (DW),
    .IE_BIT   (IE_BIT),
    .AUTO_BIT (AUTO_BIT),
    .EV_BIT   (EV_BIT)
  ) u_ctlstat (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wstb.wr_ctrl),
    .wr_status (wstb.wr_status),
    .ie_wd     (bus_wdata[IE_BIT]),
    .auto_wd   (bus_wdata[AUTO_BIT]),
    .clr_wd    (bus_wdata[EV_BIT]),
    .expire    (expire),
    .glob_ie   (glob_ie),
    .ie_q      (ie_val),
    .auto_q    (auto_val),
    .ev_q      (ev_val),
    .clr_ev    (clr_ev),
    .ctrl_rd   (ctrl_rd),
    .status_rd (status_rd),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/dec_timer_sva.sv
module dec_timer_sva #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          glob_ie,
  input logic          irq_o,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] count_val,
  input logic [DW-1:0] reload_val,
  input logic          ie_val,
  input logic          auto_val,
  input logic          ev_val,
  input logic          clr_ev,
  input logic          expire,
  input logic          wr_count
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  p_step_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_count && count_val > ONE) |=> (count_val == $past(count_val) - ONE));

  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_count) |=> $stable(count_val));

  p_event_on_expiry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_count && count_val == ONE) |=> ev_val);

  p_no_spurious_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_val && !(tick && !wr_count && count_val == ONE)) |=> !ev_val);

  p_park_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_count && count_val == ONE && !auto_val) |=> (count_val == '0));

  p_stay_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_val == '0 && !wr_count) |=> (count_val == '0));

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_count && count_val == ONE && auto_val) |=> (count_val == $past(reload_val)));

  p_local_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_val |-> !irq_o);

  p_needs_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ev_val);

  p_global_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_ie |-> !irq_o);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_val && !clr_ev) |=> ev_val);

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> (count_val == $past(bus_wdata)));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && clr_ev) |=> ev_val);
endmodule

bind dec_timer dec_timer_sva #(.DW(DW)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .glob_ie    (glob_ie),
  .irq_o      (irq_o),
  .bus_wdata  (bus_wdata),
  .count_val  (count_val),
  .reload_val (reload_val),
  .ie_val     (ie_val),
  .auto_val   (auto_val),
  .ev_val     (ev_val),
  .clr_ev     (clr_ev),
  .expire     (expire),
  .wr_count   (wstb.wr_count)
);

// File: tb/tb_dec_timer.sv
`timescale 1ns/1ps
module tb_dec_timer;
  localparam int unsigned IEB = 26;
  localparam int unsigned ARB = 22;
  localparam int unsigned EVB = 27;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        tick;
  logic        glob_ie;
  logic        irq_o;

  int n_chk;
  int n_fail;

  logic [31:0] m_cnt;
  logic [31:0] m_rel;
  logic        m_ie;
  logic        m_auto;
  logic        m_ev;

  dec_timer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick      (tick),
    .glob_ie   (glob_ie),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      2'd0: v = m_cnt;
      2'd1: begin v[IEB] = m_ie; v[ARB] = m_auto; end
      2'd2: v[EVB] = m_ev;
      default: v = m_rel;
    endcase
    return v;
  endfunction

  function automatic logic [31:0] ctrl_word(input logic ie, input logic ar, input logic [31:0] junk);
    logic [31:0] v;
    v = junk;
    v[IEB] = ie;
    v[ARB] = ar;
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic w, input logic [1:0] a,
                     input logic [31:0] d, input logic t, input logic g,
                     input string tag);
    logic        wr_any;
    logic        set_ev;
    logic        clr;
    logic [31:0] nc;
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; tick = t; glob_ie = g;
    #1;
    check({tag, " rdata"}, bus_rdata, exp_read(a));
    check({tag, " irq"}, {31'b0, irq_o}, {31'b0, m_ev & m_ie & g});
    @(posedge clk);
    wr_any = s & w;
    clr    = wr_any && a == 2'd2 && d[EVB];
    set_ev = 1'b0;
    nc     = m_cnt;
    if (wr_any && a == 2'd0) nc = d;
    else if (t && m_cnt != 0) begin
      if (m_cnt == 32'd1) begin
        set_ev = 1'b1;
        nc = m_auto ? m_rel : 32'd0;
      end else nc = m_cnt - 32'd1;
    end
    m_cnt = nc;
    m_ev  = set_ev | (m_ev & ~clr);
    if (wr_any && a == 2'd1) begin m_ie = d[IEB]; m_auto = d[ARB]; end
    if (wr_any && a == 2'd3) m_rel = d;
  endtask

  task automatic rd(input logic [1:0] a, input logic g, input string tag);
    cyc(1'b1, 1'b0, a, 32'h0, 1'b0, g, tag);
  endtask

  task automatic wrt(input logic [1:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, 1'b0, 1'b1, tag);
  endtask

  task automatic tk(input string tag);
    cyc(1'b0, 1'b0, 2'd0, 32'h0, 1'b1, 1'b1, tag);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    n_chk = 0; n_fail = 0;
    m_cnt = 0; m_rel = 0; m_ie = 0; m_auto = 0; m_ev = 0;
    seed = $urandom(32'd24681);
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    tick = 0; glob_ie = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R11: everything zero after reset
    rd(2'd0, 1'b1, "R11");
    rd(2'd1, 1'b1, "R11");
    rd(2'd2, 1'b1, "R11");
    rd(2'd3, 1'b1, "R11");
    // R12: unused control bits read zero
    wrt(2'd1, ctrl_word(1'b0, 1'b0, 32'hF0F0_00FF), "R12");
    rd(2'd1, 1'b1, "R12");
    wrt(2'd2, 32'hFFFF_FFFF & ~(32'd1 << EVB), "R12");
    rd(2'd2, 1'b1, "R12");
    // R9 load, R1 step and hold
    wrt(2'd0, 32'd3, "R9");
    rd(2'd0, 1'b1, "R9");
    tk("R1");
    cyc(1'b1, 1'b0, 2'd0, 32'h0, 1'b0, 1'b1, "R1");
    tk("R1");
    // R2 and R5: expiry with local enable off
    tk("R2");
    rd(2'd2, 1'b1, "R5");
    rd(2'd0, 1'b1, "R3");
    tk("R3");
    tk("R3");
    rd(2'd0, 1'b1, "R3");
    // R8: enable written while event pending
    wrt(2'd1, ctrl_word(1'b1, 1'b0, 32'h0), "R8");
    rd(2'd2, 1'b1, "R8");
    // R6: global enable drops the output
    rd(2'd2, 1'b0, "R6");
    rd(2'd2, 1'b1, "R6");
    // R7: zero mask keeps, one mask clears
    wrt(2'd2, 32'h0, "R7");
    rd(2'd2, 1'b1, "R7");
    wrt(2'd2, 32'd1 << EVB, "R7");
    rd(2'd2, 1'b1, "R7");
    // R4: auto reload
    wrt(2'd3, 32'd5, "R4");
    wrt(2'd1, ctrl_word(1'b1, 1'b1, 32'h0), "R4");
    wrt(2'd0, 32'd1, "R4");
    tk("R4");
    rd(2'd0, 1'b1, "R4");
    rd(2'd2, 1'b1, "R4");
    tk("R4");
    rd(2'd0, 1'b1, "R4");
    // R9: write beats expiry
    wrt(2'd2, 32'd1 << EVB, "R9");
    wrt(2'd0, 32'd1, "R9");
    cyc(1'b1, 1'b1, 2'd0, 32'd9, 1'b1, 1'b1, "R9");
    rd(2'd0, 1'b1, "R9");
    rd(2'd2, 1'b1, "R9");
    // R10: set beats clear
    wrt(2'd0, 32'd1, "R10");
    cyc(1'b1, 1'b1, 2'd2, 32'd1 << EVB, 1'b1, 1'b1, "R10");
    rd(2'd2, 1'b1, "R10");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic        s, w, t, g;
      logic [1:0]  a;
      logic [31:0] d;
      s = ($urandom % 3) == 0;
      w = $urandom % 2;
      a = 2'($urandom % 4);
      case (a)
        2'd0:    d = $urandom % 12;
        2'd3:    d = $urandom % 8;
        default: d = $urandom;
      endcase
      t = $urandom % 2;
      g = ($urandom % 8) != 0;
      cyc(s, w, a, d, t, g, "R1/R6 random");
    end
    rd(2'd2, 1'b1, "R7 final");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule